// File: doc/BRIEF.md
# Pipelined Quintic Polynomial Evaluator

This block computes y = a0 + a1·x + a2·x^2 + a3·x^3 + a4·x^4 + a5·x^5 on signed integers. It accepts a new operand set every clock cycle. An input strobe marks the operand set as valid. The result leaves the block a fixed number of cycles later, together with its own valid strobe. No handshake or stall path exists, so the caller may drive a valid operand set on every cycle or leave gaps at any point.

The powers of x are built in a chain of power stages. A final stage forms all six coefficient products in parallel and adds them in a balanced tree. Every power and every coefficient moves forward in step with the valid bit, so the final stage sees all of them together.

A parameter selects the structure:
- **Dual-multiplier shape (default).** Each power stage chains two multipliers: x^2 and x^3 in the first stage, x^4 and x^5 in the second. The latency is three cycles.
- **Single-multiplier shape.** Each power stage holds one multiplier. The latency is five cycles.

Every power is kept at full precision, and the result is wide enough that no operand set can overflow it.

Top module: `qpe_poly5`

## Requirements
- R1: When the output valid is high, `y_o` equals the exact signed sum a0 + a1·x + … + a5·x^5. Coefficient ai is read from `coef_i[i*W +: W]` as a W-bit two's-complement value, and x is read from `x_i`, also two's complement.
- R2: In the dual-multiplier shape, an operand set that is sampled with `in_vld_i` high at clock edge k appears on the outputs after edge k+2, which is three registers. `out_vld_o` after edge k+2 equals `in_vld_i` at edge k.
- R3: In the single-multiplier shape, the same relation holds with five registers: `out_vld_o` after edge k+4 equals `in_vld_i` at edge k.
- R4: Valid operand sets on consecutive cycles produce correct results on consecutive cycles. The sustained rate is one result per clock.
- R5: A cycle with `in_vld_i` low produces a cycle with `out_vld_o` low exactly one latency later. The data presented in that cycle has no effect on any later result.
- R6: While `rst_i` is high at a clock edge, every in-flight valid bit is cleared, including the one for the operand set presented at that edge. After reset, `out_vld_o` stays low until the first post-reset valid operand set arrives.
- R7: The result is exact at the extremes: x and every coefficient at the most negative value, at the most positive value, and mixed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset; clears the valid bits only |
| in_vld_i | input | 1 | Marks the operand set on `coef_i` and `x_i` as valid |
| coef_i | input | 6*W | Six signed coefficients; ai occupies bits [i*W +: W] |
| x_i | input | W | Signed variable x |
| out_vld_o | output | 1 | Marks `y_o` as a valid result |
| y_o | output | 6*W+3 | Signed polynomial value |

## Verification
The hardest situation to produce is reset arriving while valid operand sets are spread across the stages, with a valid set presented at the same edge. That situation shows whether every stage drops its valid bit, or whether a stale result leaks out after reset. The bench holds the input strobe high while it pulses reset in the middle of a dense random stream. It then checks that the outputs stay invalid until the first post-reset set has had time to pass through.

The bench drives the same stimulus into both pipeline shapes side by side, so that the three-cycle and five-cycle alignments are checked against identical traffic. The stimulus includes:
- bursts with no gaps;
- streams with random gaps in the strobe;
- directed sets that drive x and the coefficients to their most negative and most positive values, so the widest power x^5 is tested at full magnitude.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

   // Number of coefficients a0..a5
   localparam int N_COEF = 6;

   // Pipeline shape: two chained multipliers per power stage, or one
   typedef enum logic {
      PIPE_DUAL_MULT   = 1'b0,
      PIPE_SINGLE_MULT = 1'b1
   } pipe_shape_e;

   // Register count from input to output for a given shape
   function automatic int pipe_depth(pipe_shape_e shape);
      return (shape == PIPE_SINGLE_MULT) ? 5 : 3;
   endfunction

endpackage

// File: rtl/qpe_mul.sv
// Full-precision signed multiplier; product is AW+BW bits so it never wraps.
module qpe_mul #(
   parameter int AW = 8,
   parameter int BW = 8,
   localparam int PW = AW + BW
) (
   input  logic signed [AW-1:0] a_i,
   input  logic signed [BW-1:0] b_i,
   output logic signed [PW-1:0] p_o
);

   if (AW < 1 || BW < 1) begin : g_bad_width
      $error("qpe_mul: operand widths must be positive");
   end

   assign p_o = PW'(a_i) * PW'(b_i);

   // R1
   always_comb begin
      if (a_i != '0 && b_i != '0) begin
         mul_sign_chk: assert (p_o[PW-1] == (a_i[AW-1] ^ b_i[BW-1]));
      end
   end

endmodule

// File: rtl/qpe_stage_reg.sv
// One pipeline boundary: valid bit with synchronous reset, payload without.
module qpe_stage_reg #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          vld_i,
   input  logic [DW-1:0] d_i,
   output logic          vld_o,
   output logic [DW-1:0] d_o
);

   if (DW < 1) begin : g_bad_width
      $error("qpe_stage_reg: payload width must be positive");
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) vld_o <= 1'b0;
      else       vld_o <= vld_i;
   end

   always_ff @(posedge clk_i) begin
      d_o <= d_i;
   end

   // R6
   reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> !vld_o);

endmodule

// File: rtl/qpe_wsum.sv
// Final stage: six parallel coefficient products and a balanced adder tree.
module qpe_wsum
   import qpe_pkg::*;
#(
   parameter int W = 8,
   localparam int PWR_W = 5 * W,
   localparam int PRD_W = 6 * W,
   localparam int RES_W = 6 * W + 3
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    vld_i,
   input  logic [N_COEF*W-1:0]     coef_i,
   input  logic signed [W-1:0]     x_i,
   input  logic signed [2*W-1:0]   sq_i,
   input  logic signed [3*W-1:0]   cu_i,
   input  logic signed [4*W-1:0]   q4_i,
   input  logic signed [5*W-1:0]   q5_i,
   output logic                    vld_o,
   output logic signed [RES_W-1:0] y_o
);

   logic signed [PWR_W-1:0] pw   [N_COEF];
   logic signed [PRD_W-1:0] term [N_COEF];
   logic signed [RES_W-1:0] s01, s23, s45, s0123, total;

   // x^0 is the constant one; the rest are sign-extended to a common width
   assign pw[0] = PWR_W'(1);
   assign pw[1] = PWR_W'(x_i);
   assign pw[2] = PWR_W'(sq_i);
   assign pw[3] = PWR_W'(cu_i);
   assign pw[4] = PWR_W'(q4_i);
   assign pw[5] = q5_i;

   for (genvar i = 0; i < N_COEF; i++) begin : g_term
      qpe_mul #(.AW(W), .BW(PWR_W)) u_term (
         .a_i (coef_i[i*W +: W]),
         .b_i (pw[i]),
         .p_o (term[i])
      );
   end

   // Three-level tree of two-input adders
   assign s01   = RES_W'(term[0]) + RES_W'(term[1]);
   assign s23   = RES_W'(term[2]) + RES_W'(term[3]);
   assign s45   = RES_W'(term[4]) + RES_W'(term[5]);
   assign s0123 = s01 + s23;
   assign total = s0123 + s45;

   always_ff @(posedge clk_i) begin
      if (rst_i) vld_o <= 1'b0;
      else       vld_o <= vld_i;
   end

   always_ff @(posedge clk_i) begin
      y_o <= total;
   end

endmodule

// File: rtl/qpe_poly5.sv
// Pipelined evaluator of a fifth-degree signed integer polynomial.
module qpe_poly5
   import qpe_pkg::*;
#(
   parameter int          W     = 8,
   parameter pipe_shape_e SHAPE = PIPE_DUAL_MULT,
   localparam int         RES_W = 6 * W + 3
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    in_vld_i,
   input  logic [N_COEF*W-1:0]     coef_i,
   input  logic signed [W-1:0]     x_i,
   output logic                    out_vld_o,
   output logic signed [RES_W-1:0] y_o
);

   localparam int LAT = pipe_depth(SHAPE);
   localparam int CW  = N_COEF * W;
   localparam int CNT_W = $clog2(LAT + 2);

   if (W < 2) begin : g_bad_w
      $error("qpe_poly5: W must be at least 2");
   end
   if (LAT < 3) begin : g_bad_lat
      $error("qpe_poly5: pipeline depth below three stages");
   end

   // Bundle seen by the weighted-sum stage
   logic                  fin_vld;
   logic [CW-1:0]         fin_coef;
   logic signed [W-1:0]   fin_x;
   logic signed [2*W-1:0] fin_sq;
   logic signed [3*W-1:0] fin_cu;
   logic signed [4*W-1:0] fin_q4;
   logic signed [5*W-1:0] fin_q5;

   if (SHAPE == PIPE_DUAL_MULT) begin : g_dual
      logic signed [2*W-1:0] sq_c;
      logic signed [3*W-1:0] cu_c;
      logic signed [4*W-1:0] q4_c;
      logic signed [5*W-1:0] q5_c;
      logic                  s1_vld;
      logic [CW-1:0]         s1_coef;
      logic signed [W-1:0]   s1_x;
      logic signed [2*W-1:0] s1_sq;
      logic signed [3*W-1:0] s1_cu;

      // Stage 1: x^2 then x^3, chained
      qpe_mul #(.AW(W), .BW(W)) u_sq (.a_i(x_i), .b_i(x_i), .p_o(sq_c));
      qpe_mul #(.AW(2*W), .BW(W)) u_cu (.a_i(sq_c), .b_i(x_i), .p_o(cu_c));

      qpe_stage_reg #(.DW(CW + 6*W)) u_s1 (
         .clk_i, .rst_i,
         .vld_i (in_vld_i),
         .d_i   ({coef_i, x_i, sq_c, cu_c}),
         .vld_o (s1_vld),
         .d_o   ({s1_coef, s1_x, s1_sq, s1_cu})
      );

      // Stage 2: x^4 then x^5, chained
      qpe_mul #(.AW(3*W), .BW(W)) u_q4 (.a_i(s1_cu), .b_i(s1_x), .p_o(q4_c));
      qpe_mul #(.AW(4*W), .BW(W)) u_q5 (.a_i(q4_c), .b_i(s1_x), .p_o(q5_c));

      qpe_stage_reg #(.DW(CW + 15*W)) u_s2 (
         .clk_i, .rst_i,
         .vld_i (s1_vld),
         .d_i   ({s1_coef, s1_x, s1_sq, s1_cu, q4_c, q5_c}),
         .vld_o (fin_vld),
         .d_o   ({fin_coef, fin_x, fin_sq, fin_cu, fin_q4, fin_q5})
      );
   end else begin : g_single
      logic signed [2*W-1:0] sq_c;
      logic signed [3*W-1:0] cu_c;
      logic signed [4*W-1:0] q4_c;
      logic signed [5*W-1:0] q5_c;
      logic                  s1_vld, s2_vld, s3_vld;
      logic [CW-1:0]         s1_coef, s2_coef, s3_coef;
      logic signed [W-1:0]   s1_x, s2_x, s3_x;
      logic signed [2*W-1:0] s1_sq, s2_sq, s3_sq;
      logic signed [3*W-1:0] s2_cu, s3_cu;
      logic signed [4*W-1:0] s3_q4;

      // Stage 1: x^2
      qpe_mul #(.AW(W), .BW(W)) u_sq (.a_i(x_i), .b_i(x_i), .p_o(sq_c));
      qpe_stage_reg #(.DW(CW + 3*W)) u_s1 (
         .clk_i, .rst_i,
         .vld_i (in_vld_i),
         .d_i   ({coef_i, x_i, sq_c}),
         .vld_o (s1_vld),
         .d_o   ({s1_coef, s1_x, s1_sq})
      );

      // Stage 2: x^3
      qpe_mul #(.AW(2*W), .BW(W)) u_cu (.a_i(s1_sq), .b_i(s1_x), .p_o(cu_c));
      qpe_stage_reg #(.DW(CW + 6*W)) u_s2 (
         .clk_i, .rst_i,
         .vld_i (s1_vld),
         .d_i   ({s1_coef, s1_x, s1_sq, cu_c}),
         .vld_o (s2_vld),
         .d_o   ({s2_coef, s2_x, s2_sq, s2_cu})
      );

      // Stage 3: x^4
      qpe_mul #(.AW(3*W), .BW(W)) u_q4 (.a_i(s2_cu), .b_i(s2_x), .p_o(q4_c));
      qpe_stage_reg #(.DW(CW + 10*W)) u_s3 (
         .clk_i, .rst_i,
         .vld_i (s2_vld),
         .d_i   ({s2_coef, s2_x, s2_sq, s2_cu, q4_c}),
         .vld_o (s3_vld),
         .d_o   ({s3_coef, s3_x, s3_sq, s3_cu, s3_q4})
      );

      // Stage 4: x^5
      qpe_mul #(.AW(4*W), .BW(W)) u_q5 (.a_i(s3_q4), .b_i(s3_x), .p_o(q5_c));
      qpe_stage_reg #(.DW(CW + 15*W)) u_s4 (
         .clk_i, .rst_i,
         .vld_i (s3_vld),
         .d_i   ({s3_coef, s3_x, s3_sq, s3_cu, s3_q4, q5_c}),
         .vld_o (fin_vld),
         .d_o   ({fin_coef, fin_x, fin_sq, fin_cu, fin_q4, fin_q5})
      );
   end

   qpe_wsum #(.W(W)) u_wsum (
      .clk_i, .rst_i,
      .vld_i  (fin_vld),
      .coef_i (fin_coef),
      .x_i    (fin_x),
      .sq_i   (fin_sq),
      .cu_i   (fin_cu),
      .q4_i   (fin_q4),
      .q5_i   (fin_q5),
      .vld_o  (out_vld_o),
      .y_o    (y_o)
   );

   // Checking state: cycles since reset release, and results in flight
   logic [CNT_W-1:0] since_rst;
   logic [CNT_W-1:0] in_flight;

   always_ff @(posedge clk_i) begin
      if (rst_i) since_rst <= '0;
      else if (since_rst < CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) in_flight <= '0;
      else       in_flight <= in_flight + CNT_W'(in_vld_i) - CNT_W'(out_vld_o);
   end

   // R1
   even_power_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      fin_vld |-> (!fin_sq[2*W-1] && !fin_q4[4*W-1]));

   // R2 R3
   latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (since_rst >= CNT_W'(LAT)) |-> (out_vld_o == $past(in_vld_i, LAT)));

   // R4
   in_flight_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      in_flight <= CNT_W'(LAT));

   // R6
   post_reset_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (since_rst < CNT_W'(LAT)) |-> !out_vld_o);

endmodule

// File: tb/qpe_poly5_test.sv
`timescale 1ns/1ps
module qpe_poly5_test;
   import qpe_pkg::*;

   localparam int W     = 8;
   localparam int RES_W = 6 * W + 3;
   localparam int LAT_A = 3;
   localparam int LAT_B = 5;
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    in_vld = 1'b0;
   logic [6*W-1:0]          coef = '0;
   logic signed [W-1:0]     x = '0;
   logic                    vld_a, vld_b;
   logic signed [RES_W-1:0] y_a, y_b;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   string tag      = "R6 reset";

   always #2.5 clk = ~clk;

   qpe_poly5 #(.W(W), .SHAPE(PIPE_DUAL_MULT)) uut (
      .clk_i(clk), .rst_i(rst), .in_vld_i(in_vld), .coef_i(coef), .x_i(x),
      .out_vld_o(vld_a), .y_o(y_a));

   qpe_poly5 #(.W(W), .SHAPE(PIPE_SINGLE_MULT)) uut_one (
      .clk_i(clk), .rst_i(rst), .in_vld_i(in_vld), .coef_i(coef), .x_i(x),
      .out_vld_o(vld_b), .y_o(y_b));

   function automatic longint ref_poly(input logic [6*W-1:0] c, input logic signed [W-1:0] xv);
      longint acc = 0;
      longint pw  = 1;
      for (int i = 0; i < 6; i++) begin
         acc = acc + longint'($signed(c[i*W +: W])) * pw;
         pw  = pw * longint'(xv);
      end
      return acc;
   endfunction

   // Expected-value pipelines, one per shape
   logic [LAT_A-1:0] hv_a;
   logic [LAT_B-1:0] hv_b;
   longint           he_a [LAT_A];
   longint           he_b [LAT_B];

   always @(posedge clk) begin
      if (rst) begin
         hv_a <= '0;
         hv_b <= '0;
      end else begin
         hv_a <= {hv_a[LAT_A-2:0], in_vld};
         hv_b <= {hv_b[LAT_B-2:0], in_vld};
      end
      he_a[0] <= ref_poly(coef, x);
      he_b[0] <= ref_poly(coef, x);
      for (int i = 1; i < LAT_A; i++) he_a[i] <= he_a[i-1];
      for (int i = 1; i < LAT_B; i++) he_b[i] <= he_b[i-1];
   end

   task automatic compare();
      n_checks++;
      if (vld_a !== hv_a[LAT_A-1]) begin
         n_fails++;
         $display("FAIL %s R2 valid (3-stage): got %0b expected %0b", tag, vld_a, hv_a[LAT_A-1]);
      end
      n_checks++;
      if (vld_b !== hv_b[LAT_B-1]) begin
         n_fails++;
         $display("FAIL %s R3 valid (5-stage): got %0b expected %0b", tag, vld_b, hv_b[LAT_B-1]);
      end
      if (hv_a[LAT_A-1] && vld_a === 1'b1) begin
         n_checks++;
         if (longint'(y_a) != he_a[LAT_A-1]) begin
            n_fails++;
            $display("FAIL %s R1 result (3-stage): got %0d expected %0d", tag, longint'(y_a), he_a[LAT_A-1]);
         end
      end
      if (hv_b[LAT_B-1] && vld_b === 1'b1) begin
         n_checks++;
         if (longint'(y_b) != he_b[LAT_B-1]) begin
            n_fails++;
            $display("FAIL %s R1 result (5-stage): got %0d expected %0d", tag, longint'(y_b), he_b[LAT_B-1]);
         end
      end
   endtask

   // Check the cycle that just completed, then present the next operand set
   task automatic drive(input logic v, input logic [6*W-1:0] c, input logic [W-1:0] xv);
      @(negedge clk);
      compare();
      in_vld = v;
      coef   = c;
      x      = xv;
   endtask

   function automatic logic [6*W-1:0] rnd_coef();
      return {$urandom, $urandom};
   endfunction

   initial begin
      int seed_ret;
      seed_ret = $urandom(32'h5eed_0042);
      // R6: valid operand sets offered during reset must be dropped
      tag = "R6 reset";
      for (int i = 0; i < 6; i++) drive(1'b1, rnd_coef(), W'($urandom));
      @(negedge clk);
      compare();
      rst = 1'b0;
      in_vld = 1'b0;

      // R7: extreme operands, back to back
      tag = "R7 extremes";
      drive(1'b1, {6{MINV}}, MINV);
      drive(1'b1, {6{MAXV}}, MAXV);
      drive(1'b1, {6{MAXV}}, MINV);
      drive(1'b1, {6{MINV}}, MAXV);
      drive(1'b1, {MINV, MAXV, MINV, MAXV, MINV, MAXV}, MINV);
      drive(1'b1, {6{MAXV}}, '0);
      drive(1'b1, {6{MINV}}, W'(1));
      drive(1'b1, {6{MAXV}}, '1);

      // R5: idle bubbles with garbage data
      tag = "R5 idle";
      for (int i = 0; i < 8; i++) drive(1'b0, rnd_coef(), W'($urandom));

      // R5: random stream with gaps
      tag = "R5 gaps";
      for (int i = 0; i < 600; i++)
         drive(($urandom % 10) < 6, rnd_coef(), W'($urandom));

      // R4: long back-to-back burst
      tag = "R4 burst";
      for (int i = 0; i < 300; i++) drive(1'b1, rnd_coef(), W'($urandom));

      // R6: reset while the pipes are full, strobe held high
      tag = "R6 mid-stream reset";
      @(negedge clk);
      compare();
      rst = 1'b1;
      for (int i = 0; i < 2; i++) drive(1'b1, rnd_coef(), W'($urandom));
      @(negedge clk);
      compare();
      rst = 1'b0;
      in_vld = 1'b0;
      for (int i = 0; i < 4; i++) drive(1'b0, rnd_coef(), W'($urandom));
      for (int i = 0; i < 20; i++) drive(1'b1, rnd_coef(), W'($urandom));

      // Drain
      tag = "R5 drain";
      for (int i = 0; i < 10; i++) drive(1'b0, '0, '0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL R4 watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule